// File: doc/BRIEF.md
# Serial Extension Interrupt and Timer Controller

This block merges the event sources of a serial port's external FIFO extension into one interrupt line. It keeps five pending latches (periodic timer expiry, character timeout, transmit FIFO empty, transmit FIFO below half, receive FIFO at or above half). The line-status and modem-status requests from the UART core join them directly. Each latched source has its own clear rule, driven by register accesses and FIFO strobes. An enable mask selects which latched sources reach the output. A mode bit chooses a level output or a one-clock pulse per new request.

A small register window holds the mode, the enable mask, a timer interval and a timer control bit, and exposes a status byte. The timer counts `n` periods of `PRESCALE` clocks, where `PRESCALE` clocks make 0.2 ms. It then latches its expiry and stops. Software must clear and set the control bit again to arm it once more. Read data follows `reg_addr` combinationally. Side effects of a read happen only on a `reg_rd` strobe.

Timer states: `TM_OFF` (control bit clear), `TM_RUN` (counting), `TM_DONE` (expired, holding the request). Transitions: OFF→RUN on a write of 1 to the control bit. RUN→DONE when the count completes with `n` ≠ 0. RUN→OFF and DONE→OFF on a write of 0. Output states: `IO_LOW`, `IO_LEVEL`, `IO_PULSE`, `IO_WAIT`. Transitions: LOW→LEVEL (request, level mode). LOW→PULSE (request, edge mode). PULSE→WAIT (request held, edge mode). PULSE→LEVEL (request held, level mode). LEVEL→WAIT (mode switched to edge). WAIT→LEVEL (mode switched to level). Any state goes back to LOW when the request drops.

Top module: `sxi_irq_ctrl`

## Requirements
- R1: After reset all registers read 0, `irq` is 0, `flow_auto` is 0, and status bits 7 and 6 are 0.
- R2: Offset 0 stores bit 4 (1 = level output, 0 = edge output) and bit 3 (drives `flow_auto`), and its other bits read 0. Offset 1 stores enable bits 4..0 and reads 0 above them. Offset 3 stores the 8-bit interval. Offset 4 bit 0 reads 1 whenever the timer is not in `TM_OFF`.
- R3: The status byte at offset 2 is, from bit 7 down: timer expired, character timeout pending, `rx_full`, `rx_half`, `rx_empty`, `tx_full`, `tx_half`, `tx_empty`, all active high. Writes to offset 2 have no effect.
- R4: After a write of 1 to offset 4 bit 0 from `TM_OFF`, with interval n ≥ 1, status bit 7 rises exactly n×`PRESCALE` clock edges after the write edge. It then stays set, even if 1 is written again, until bit 0 is written 0. That write clears it in the next cycle.
- R5: With interval 0 the timer never expires.
- R6: A `char_to` pulse sets the character-timeout pending bit. An `rx_fifo_rd` strobe or a status read strobe clears it.
- R7: A rising edge of `tx_empty` sets the Tx-empty source (enable bit 2). A `tx_fifo_wr` strobe or a status read strobe clears it.
- R8: A falling edge of `tx_half` sets the Tx-half source (enable bit 1). A rising edge of `tx_half` or a status read strobe clears it.
- R9: The Rx-half source (enable bit 0) follows `rx_half` directly.
- R10: A latched source requests an interrupt only while its enable bit is set (bit 4 timer, bit 3 character timeout). `uart_ls_irq` and `uart_ms_irq` always request.
- R11: In level mode `irq` follows the combined request with one clock of delay.
- R12: In edge mode `irq` is high for exactly one clock after each 0→1 change of the combined request, and stays low while the request stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers read side effects) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| tx_empty | input | 1 | Tx FIFO empty flag |
| tx_half | input | 1 | Tx FIFO at or above half flag |
| tx_full | input | 1 | Tx FIFO full flag |
| rx_empty | input | 1 | Rx FIFO empty flag |
| rx_half | input | 1 | Rx FIFO at or above half flag |
| rx_full | input | 1 | Rx FIFO full flag |
| char_to | input | 1 | Character-timeout detector pulse |
| rx_fifo_rd | input | 1 | Rx FIFO read strobe |
| tx_fifo_wr | input | 1 | Tx FIFO write strobe |
| uart_ls_irq | input | 1 | Line-status request from UART core |
| uart_ms_irq | input | 1 | Modem-status request from UART core |
| flow_auto | output | 1 | Automatic RTS/CTS flow control enable |
| irq | output | 1 | Interrupt output |

## Verification
A wrong timer state shows at status bit 7. A premature or missing expiry appears at exactly the n×`PRESCALE` edge. A lost clear shows as the bit surviving the control write by more than one cycle. A stuck pending latch for the Tx sources is only visible through `irq`. It shows one clock after the clearing strobe, because the output FSM adds a single register. A corrupted output state shows within one to two cycles, as a pulse that lasts more than one clock in edge mode or as `irq` failing to track the request in level mode.

// File: rtl/sxi_pkg.sv
package sxi_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int SRC_N  = 5;

    localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] A_IEN  = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
    localparam logic [ADDR_W-1:0] A_IVAL = 3'd3;
    localparam logic [ADDR_W-1:0] A_TCTL = 3'd4;

    localparam int S_RXH = 0;
    localparam int S_TXH = 1;
    localparam int S_TXE = 2;
    localparam int S_CHR = 3;
    localparam int S_TMR = 4;

    localparam int M_LVL  = 4;
    localparam int M_FLOW = 3;

    typedef enum logic [1:0] {TM_OFF, TM_RUN, TM_DONE} tmr_st_t;
    typedef enum logic [1:0] {IO_LOW, IO_LEVEL, IO_PULSE, IO_WAIT} irq_st_t;
endpackage

// File: rtl/sxi_regs.sv
module sxi_regs
    import sxi_pkg::*;
#(
    parameter int IW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              mode_lvl,
    output logic              mode_flow,
    output logic [SRC_N-1:0]  ien,
    output logic [IW-1:0]     ival,
    output logic              tctl_set,
    output logic              tctl_clr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_lvl  <= 1'b0;
            mode_flow <= 1'b0;
            ien       <= '0;
            ival      <= '0;
        end else if (wr) begin
            if (addr == A_MODE) begin
                mode_lvl  <= wdata[M_LVL];
                mode_flow <= wdata[M_FLOW];
            end
            if (addr == A_IEN)  ien  <= wdata[SRC_N-1:0];
            if (addr == A_IVAL) ival <= wdata[IW-1:0];
        end
    end

    assign tctl_set = wr && (addr == A_TCTL) &&  wdata[0];
    assign tctl_clr = wr && (addr == A_TCTL) && !wdata[0];
endmodule

// File: rtl/sxi_timer.sv
module sxi_timer
    import sxi_pkg::*;
#(
    parameter int PRESCALE = 40000,
    parameter int IW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_set,
    input  logic          en_clr,
    input  logic [IW-1:0] ival,
    output logic          fired,
    output logic          active
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

    tmr_st_t       st_q, st_d;
    logic [PW-1:0] pre_q;
    logic [IW:0]   tick_q;
    logic          tick, done_now;

    assign tick     = (pre_q == PRE_LAST);
    assign done_now = tick && (ival != '0) && ((tick_q + 1'b1) >= {1'b0, ival});

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TM_OFF:  if (en_set) st_d = TM_RUN;
            TM_RUN:  if (en_clr) st_d = TM_OFF;
                     else if (done_now) st_d = TM_DONE;
            TM_DONE: if (en_clr) st_d = TM_OFF;
            default: st_d = TM_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TM_OFF;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            tick_q <= '0;
        end else if (st_q != TM_RUN) begin
            pre_q  <= '0;
            tick_q <= '0;
        end else if (tick) begin
            pre_q  <= '0;
            tick_q <= tick_q + 1'b1;
        end else begin
            pre_q  <= pre_q + 1'b1;
        end
    end

    always_comb begin
        fired  = (st_q == TM_DONE);
        active = (st_q != TM_OFF);
    end
endmodule

// File: rtl/sxi_src.sv
module sxi_src
    import sxi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_empty,
    input  logic             tx_half,
    input  logic             rx_half,
    input  logic             char_to,
    input  logic             rx_rd,
    input  logic             tx_wr,
    input  logic             stat_rd,
    input  logic             tmr_fired,
    input  logic [SRC_N-1:0] ien,
    input  logic             uart_ls,
    input  logic             uart_ms,
    output logic [SRC_N-1:0] pend,
    output logic             any_req
);
    logic txe_prev, txh_prev;
    logic txe_q, txh_q, chr_q;
    logic txe_set, txh_set, txh_rise;

    assign txe_set  =  tx_empty && !txe_prev;
    assign txh_set  = !tx_half  &&  txh_prev;
    assign txh_rise =  tx_half  && !txh_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txe_prev <= 1'b0;
            txh_prev <= 1'b0;
            txe_q    <= 1'b0;
            txh_q    <= 1'b0;
            chr_q    <= 1'b0;
        end else begin
            txe_prev <= tx_empty;
            txh_prev <= tx_half;
            txe_q    <= txe_set || (txe_q && !(tx_wr || stat_rd));
            txh_q    <= txh_set || (txh_q && !(txh_rise || stat_rd));
            chr_q    <= char_to || (chr_q && !(rx_rd || stat_rd));
        end
    end

    always_comb begin
        pend        = '0;
        pend[S_RXH] = rx_half;
        pend[S_TXH] = txh_q;
        pend[S_TXE] = txe_q;
        pend[S_CHR] = chr_q;
        pend[S_TMR] = tmr_fired;
        any_req     = (|(pend & ien)) || uart_ls || uart_ms;
    end
endmodule

// File: rtl/sxi_out.sv
module sxi_out
    import sxi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic req,
    output logic irq
);
    irq_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IO_LOW:   if (req) st_d = lvl ? IO_LEVEL : IO_PULSE;
            IO_LEVEL: if (!req) st_d = IO_LOW;
                      else if (!lvl) st_d = IO_WAIT;
            IO_PULSE: if (!req) st_d = IO_LOW;
                      else st_d = lvl ? IO_LEVEL : IO_WAIT;
            IO_WAIT:  if (!req) st_d = IO_LOW;
                      else if (lvl) st_d = IO_LEVEL;
            default:  st_d = IO_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= IO_LOW;
        else        st_q <= st_d;
    end

    always_comb begin
        irq = (st_q == IO_LEVEL) || (st_q == IO_PULSE);
    end
endmodule

// File: rtl/sxi_irq_ctrl.sv
module sxi_irq_ctrl
    import sxi_pkg::*;
#(
    parameter int PRESCALE = 40000,
    parameter int IW       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tx_empty,
    input  logic              tx_half,
    input  logic              tx_full,
    input  logic              rx_empty,
    input  logic              rx_half,
    input  logic              rx_full,
    input  logic              char_to,
    input  logic              rx_fifo_rd,
    input  logic              tx_fifo_wr,
    input  logic              uart_ls_irq,
    input  logic              uart_ms_irq,
    output logic              flow_auto,
    output logic              irq
);
    logic             mode_lvl, tctl_set, tctl_clr, tmr_fired, tmr_active;
    logic             stat_rd, any_req;
    logic [SRC_N-1:0] ien, src_pend;
    logic [IW-1:0]    ival;

    assign stat_rd = reg_rd && (reg_addr == A_STAT);

    sxi_regs #(.IW(IW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .mode_lvl(mode_lvl), .mode_flow(flow_auto), .ien(ien), .ival(ival),
        .tctl_set(tctl_set), .tctl_clr(tctl_clr)
    );

    sxi_timer #(.PRESCALE(PRESCALE), .IW(IW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .en_set(tctl_set), .en_clr(tctl_clr), .ival(ival),
        .fired(tmr_fired), .active(tmr_active)
    );

    sxi_src u_src (
        .clk(clk), .rst_n(rst_n), .tx_empty(tx_empty), .tx_half(tx_half),
        .rx_half(rx_half), .char_to(char_to), .rx_rd(rx_fifo_rd), .tx_wr(tx_fifo_wr),
        .stat_rd(stat_rd), .tmr_fired(tmr_fired), .ien(ien), .uart_ls(uart_ls_irq),
        .uart_ms(uart_ms_irq), .pend(src_pend), .any_req(any_req)
    );

    sxi_out u_out (
        .clk(clk), .rst_n(rst_n), .lvl(mode_lvl), .req(any_req), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_MODE: begin
                reg_rdata[M_LVL]  = mode_lvl;
                reg_rdata[M_FLOW] = flow_auto;
            end
            A_IEN:  reg_rdata[SRC_N-1:0] = ien;
            A_STAT: reg_rdata = {src_pend[S_TMR], src_pend[S_CHR], rx_full, rx_half,
                                 rx_empty, tx_full, tx_half, tx_empty};
            A_IVAL: reg_rdata[IW-1:0] = ival;
            A_TCTL: reg_rdata[0] = tmr_active;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sxi_irq_chk.sv
module sxi_irq_chk
    import sxi_pkg::*;
#(
    parameter int IW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              char_to,
    input logic              tx_fifo_wr,
    input logic              tx_empty,
    input logic              irq,
    input logic              mode_lvl,
    input logic              any_req,
    input logic              tmr_active,
    input logic [IW-1:0]     ival,
    input logic [SRC_N-1:0]  src_pend
);
    // R4
    tmr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_TCTL && !reg_wdata[0]) |=> !src_pend[S_TMR]);

    // R5
    zero_ival_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_active && !src_pend[S_TMR] && ival == '0) |=> !src_pend[S_TMR]);

    // R6
    char_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_STAT && !char_to) |=> !src_pend[S_CHR]);

    // R7
    txe_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_fifo_wr && !tx_empty) |=> !src_pend[S_TXE]);

    // R11
    lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_lvl && any_req) |=> irq);

    // R12
    edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !mode_lvl) |=> !irq);

    // R11
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_req |=> !irq);
endmodule

bind sxi_irq_ctrl sxi_irq_chk #(.IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .char_to(char_to), .tx_fifo_wr(tx_fifo_wr),
    .tx_empty(tx_empty), .irq(irq), .mode_lvl(mode_lvl), .any_req(any_req),
    .tmr_active(tmr_active), .ival(ival), .src_pend(src_pend)
);

// File: tb/sim_sxi_irq_ctrl.sv
`timescale 1ns/1ps
module sim_sxi_irq_ctrl;
    localparam int PRE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 0, reg_rd = 0;
    logic [2:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic tx_empty = 0, tx_half = 0, tx_full = 0, rx_empty = 0, rx_half = 0, rx_full = 0;
    logic char_to = 0, rx_fifo_rd = 0, tx_fifo_wr = 0, uart_ls_irq = 0, uart_ms_irq = 0;
    logic flow_auto, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sxi_irq_ctrl #(.PRESCALE(PRE)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_empty(tx_empty),
        .tx_half(tx_half), .tx_full(tx_full), .rx_empty(rx_empty), .rx_half(rx_half),
        .rx_full(rx_full), .char_to(char_to), .rx_fifo_rd(rx_fifo_rd),
        .tx_fifo_wr(tx_fifo_wr), .uart_ls_irq(uart_ls_irq), .uart_ms_irq(uart_ms_irq),
        .flow_auto(flow_auto), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_stat();
        reg_rd = 1; reg_addr = 3'd2;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic pulse(ref logic s);
        s = 1;
        @(negedge clk);
        s = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 irq", irq, 0);
        chk("R1 flow_auto", flow_auto, 0);
        for (int a = 0; a < 5; a++) begin
            peek(3'(a), v);
            chk("R1 reg", v, 0);
        end
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(3'd0, 8'hFF); peek(3'd0, v); chk("R2 mode", v, 8'h18);
        chk("R2 flow_auto", flow_auto, 1);
        wr(3'd1, 8'hFF); peek(3'd1, v); chk("R2 ien", v, 8'h1F);
        wr(3'd3, 8'hA5); peek(3'd3, v); chk("R2 ival", v, 8'hA5);
        wr(3'd1, 8'h00); wr(3'd0, 8'h10);
        peek(3'd0, v); chk("R2 mode level", v, 8'h10);
        chk("R2 flow_auto off", flow_auto, 0);
    endtask

    task automatic t_status();
        logic [7:0] v;
        rx_full = 1; rx_empty = 0; tx_full = 1; tx_empty = 0; tx_half = 0; rx_half = 0;
        wr(3'd2, 8'hFF);
        peek(3'd2, v); chk("R3 status 24", v, 8'h24);
        rx_full = 0; tx_full = 0; rx_empty = 1;
        peek(3'd2, v); chk("R3 status 08", v, 8'h08);
        rx_empty = 0;
    endtask

    task automatic t_timer();
        logic [7:0] v;
        wr(3'd3, 8'd3);
        wr(3'd4, 8'd1);
        peek(3'd4, v); chk("R2 tctl active", v, 1);
        cyc(3 * PRE - 1);
        peek(3'd2, v); chk("R4 not yet", v[7], 0);
        cyc(1);
        peek(3'd2, v); chk("R4 expired", v[7], 1);
        wr(3'd4, 8'd1);
        cyc(20);
        peek(3'd2, v); chk("R4 held", v[7], 1);
        wr(3'd4, 8'd0);
        peek(3'd2, v); chk("R4 cleared", v[7], 0);
        peek(3'd4, v); chk("R4 tctl off", v, 0);
    endtask

    task automatic t_timer_zero();
        logic [7:0] v;
        wr(3'd3, 8'd0);
        wr(3'd4, 8'd1);
        cyc(60);
        peek(3'd2, v); chk("R5 no expiry", v[7], 0);
        wr(3'd4, 8'd0);
    endtask

    task automatic t_char();
        logic [7:0] v;
        pulse(char_to);
        peek(3'd2, v); chk("R6 set", v[6], 1);
        pulse(rx_fifo_rd);
        peek(3'd2, v); chk("R6 rx read clears", v[6], 0);
        pulse(char_to);
        peek(3'd2, v); chk("R6 set again", v[6], 1);
        rd_stat();
        peek(3'd2, v); chk("R6 status read clears", v[6], 0);
    endtask

    task automatic t_txe();
        wr(3'd1, 8'h04);
        tx_empty = 1; cyc(2);
        chk("R7 irq on empty", irq, 1);
        pulse(tx_fifo_wr); cyc(1);
        chk("R7 write clears", irq, 0);
        tx_empty = 0; cyc(1); tx_empty = 1; cyc(2);
        chk("R7 irq again", irq, 1);
        rd_stat(); cyc(1);
        chk("R7 status read clears", irq, 0);
        tx_empty = 0;
        wr(3'd1, 8'h00);
    endtask

    task automatic t_txh();
        wr(3'd1, 8'h02);
        tx_half = 1; cyc(2);
        chk("R8 no irq on rise", irq, 0);
        tx_half = 0; cyc(2);
        chk("R8 irq on fall", irq, 1);
        tx_half = 1; cyc(2);
        chk("R8 refill clears", irq, 0);
        tx_half = 0; cyc(2);
        chk("R8 irq again", irq, 1);
        rd_stat(); cyc(1);
        chk("R8 status read clears", irq, 0);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_mask();
        rx_half = 1; cyc(2);
        chk("R10 masked", irq, 0);
        wr(3'd1, 8'h01); cyc(1);
        chk("R9 rx half irq", irq, 1);
        rx_half = 0; cyc(2);
        chk("R9 drained", irq, 0);
        wr(3'd1, 8'h00);
        uart_ls_irq = 1; cyc(2);
        chk("R10 line status unmasked", irq, 1);
        uart_ls_irq = 0; cyc(2);
    endtask

    task automatic t_level();
        uart_ms_irq = 1; cyc(1);
        chk("R11 rise latency", irq, 1);
        cyc(5);
        chk("R11 held", irq, 1);
        uart_ms_irq = 0; cyc(1);
        chk("R11 fall latency", irq, 0);
    endtask

    task automatic t_edge();
        int n;
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h01);
        rx_half = 1;
        n = 0;
        for (int i = 0; i < 10; i++) begin cyc(1); n += irq; end
        chk("R12 single pulse", n, 1);
        n = 0;
        for (int i = 0; i < 10; i++) begin cyc(1); n += irq; end
        chk("R12 quiet while held", n, 0);
        rx_half = 0; cyc(2); rx_half = 1;
        n = 0;
        for (int i = 0; i < 10; i++) begin cyc(1); n += irq; end
        chk("R12 second pulse", n, 1);
        rx_half = 0;
        wr(3'd1, 8'h00);
    endtask

    initial begin
        cyc(4);
        rst_n = 1;
        cyc(1);
        t_reset();
        t_regs();
        t_status();
        t_timer();
        t_timer_zero();
        t_char();
        t_txe();
        t_txh();
        t_mask();
        t_level();
        t_edge();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule